// File: doc/BRIEF.md
# Two-Level Priority Bus Arbiter

This block hands a shared bus to one device at a time out of two groups of requesters. Each group (a priority level) has its own request line, the OR of its devices' requests, and its own grant line. The grant line runs through a chain of that group's devices. When the bus is free, the arbiter looks at both level request lines. It drives the grant line of the high level if that level is asking, and the low level's otherwise. Inside the chosen level, the first requesting device along the chain, at the lowest index, takes the grant and blocks it from the devices further down.

The grant is held as a tenure. Once a device owns the bus it keeps it until it pulses the release input for one cycle. A request that appears later from the other level cannot take the bus away, and neither can one from the same level. After a release the bus spends one cycle idle, and the arbiter decides again from the requests present in that idle cycle. Because the high level always wins a free bus, a high level that never stops asking keeps the low level waiting for as long as it asks.

Top module: `arb2_bus_arbiter`

## Requirements
- R1: While reset is asserted, and for the cycles until the synchronised reset lets go, every grant output is 0 and `busy` is 0.
- R2: When the bus is idle and at least one request is high, exactly one grant bit rises on the clock edge that ends that cycle.
- R3: If both levels request during an idle cycle, the grant goes to a device in `req_hi`, and `gnt_lo` stays 0.
- R4: Within one level, the requesting device with the lowest bit index (index 0 is nearest the arbiter) receives the grant.
- R5: While the bus is owned and `rel` is low, the grant vector is unchanged on the next edge, whatever requests arrive on either level.
- R6: A `rel` pulse during an owned cycle clears every grant and `busy` on the next edge. The bus then stays idle for that cycle, and a new grant can appear no earlier than the edge after it.
- R7: A `rel` pulse while the bus is idle has no effect. With no requests the outputs stay 0, and with requests the normal grant of R2 still happens.
- R8: While `busy` is 1, exactly one bit of {`gnt_hi`,`gnt_lo`} is 1. While `busy` is 0, all of them are 0.
- R9: A high-level device that requests again in every idle cycle keeps winning, so a waiting low-level device is never granted during that time.
- R10: The owner keeps its grant after it drops its own request, until it pulses `rel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_hi | input | N_DEV | Requests of the high-priority level, bit 0 nearest the arbiter |
| req_lo | input | N_DEV | Requests of the low-priority level, bit 0 nearest the arbiter |
| rel | input | 1 | One-cycle release pulse from the current owner |
| gnt_hi | output | N_DEV | One-hot grant to a high-level device, registered |
| gnt_lo | output | N_DEV | One-hot grant to a low-level device, registered |
| busy | output | 1 | Bus is owned |

## Verification
Two functions can collide in one cycle. The first is a release by the owner together with a fresh high-level request. The second is requests on both levels while the bus is idle. The bench drives a release in the same cycle that new requests from both levels appear, and it expects an empty grant after that edge and a high-level grant, at the lowest index, one edge later. It also raises a high-level request while a low-level device owns the bus, and it expects the low-level grant to stay put until its release.

// File: rtl/arb2_pkg.sv
`timescale 1ns/1ps
package arb2_pkg;
  typedef enum logic {
    LVL_LO = 1'b0,
    LVL_HI = 1'b1
  } lvl_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_OWNED = 1'b1
  } ten_st_e;

  localparam int unsigned NUM_LVL = 2;
endpackage

// File: rtl/arb2_grant_chain.sv
`timescale 1ns/1ps
// Daisy chain of one priority level: the grant enters at node 0 and is
// absorbed by the first requesting node.
module arb2_grant_chain #(
  parameter int unsigned N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             grant_line,
  input  logic [N_DEV-1:0] req,
  output logic [N_DEV-1:0] take,
  output logic             pass_out
);
  logic [N_DEV:0] link;

  assign link[0] = grant_line;

  for (genvar i = 0; i < N_DEV; i++) begin : g_node
    assign take[i]   = link[i] & req[i];
    assign link[i+1] = link[i] & ~req[i];
  end

  assign pass_out = link[N_DEV];

  a_r4_single_taker: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  for (genvar k = 1; k < N_DEV; k++) begin : g_chk
    // R4: a node further down takes only if no nearer node asks
    a_r4_nearest_first: assert property (@(posedge clk) disable iff (!rst_n)
      take[k] |-> (req[k-1:0] == '0));
  end
endmodule

// File: rtl/arb2_level_select.sv
`timescale 1ns/1ps
// Picks which level's grant line is driven while the bus is free.
module arb2_level_select (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic lvl_req_hi,
  input  logic lvl_req_lo,
  output logic gl_hi,
  output logic gl_lo
);
  logic hi_win;
  logic lo_win;

  always_comb begin
    hi_win = 1'b0;
    lo_win = 1'b0;
    if (idle) begin
      if (lvl_req_hi) begin
        hi_win = 1'b1;
      end else if (lvl_req_lo) begin
        lo_win = 1'b1;
      end
    end
  end

  assign gl_hi = hi_win;
  assign gl_lo = lo_win;

  a_r3_high_level_first: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && lvl_req_hi) |-> (gl_hi && !gl_lo));

  a_r5_no_line_when_owned: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> !(gl_hi || gl_lo));
endmodule

// File: rtl/arb2_tenure.sv
`timescale 1ns/1ps
// Holds the current owner from grant until release.
module arb2_tenure
  import arb2_pkg::*;
#(
  parameter int unsigned N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] take_hi,
  input  logic [N_DEV-1:0] take_lo,
  input  logic             rel,
  output logic             idle,
  output logic [N_DEV-1:0] gnt_hi,
  output logic [N_DEV-1:0] gnt_lo,
  output logic             busy
);
  ten_st_e          st_q, st_d;
  lvl_e             lvl_q, lvl_d;
  logic [N_DEV-1:0] own_q, own_d;
  logic             load_en;
  logic             clr_en;
  logic             upd_en;
  logic             any_take_hi;
  logic             any_take_lo;

  assign any_take_hi = |take_hi;
  assign any_take_lo = |take_lo;
  assign load_en     = (st_q == ST_IDLE) && (any_take_hi || any_take_lo);
  assign clr_en      = (st_q == ST_OWNED) && rel;
  assign upd_en      = load_en || clr_en;

  always_comb begin
    st_d  = st_q;
    lvl_d = lvl_q;
    own_d = own_q;
    if (load_en) begin
      st_d = ST_OWNED;
      if (any_take_hi) begin
        lvl_d = LVL_HI;
        own_d = take_hi;
      end else begin
        lvl_d = LVL_LO;
        own_d = take_lo;
      end
    end else if (clr_en) begin
      st_d  = ST_IDLE;
      lvl_d = LVL_LO;
      own_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      lvl_q <= LVL_LO;
      own_q <= '0;
    end else if (upd_en) begin
      st_q  <= st_d;
      lvl_q <= lvl_d;
      own_q <= own_d;
    end
  end

  assign idle   = (st_q == ST_IDLE);
  assign busy   = (st_q == ST_OWNED);
  assign gnt_hi = (busy && lvl_q == LVL_HI) ? own_q : '0;
  assign gnt_lo = (busy && lvl_q == LVL_LO) ? own_q : '0;

  a_r8_one_grant_owned: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones({gnt_hi, gnt_lo}) == 1));

  a_r8_none_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ({gnt_hi, gnt_lo} == '0));

  a_r5_hold_tenure: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rel) |=> ($stable(gnt_hi) && $stable(gnt_lo) && busy));

  a_r6_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rel) |=> !busy);

  a_r2_grant_next: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (any_take_hi || any_take_lo)) |=> busy);

  a_r7_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !any_take_hi && !any_take_lo) |=> !busy);
endmodule

// File: rtl/arb2_bus_arbiter.sv
`timescale 1ns/1ps
module arb2_bus_arbiter
  import arb2_pkg::*;
#(
  parameter int unsigned N_DEV    = 4,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] req_hi,
  input  logic [N_DEV-1:0] req_lo,
  input  logic             rel,
  output logic [N_DEV-1:0] gnt_hi,
  output logic [N_DEV-1:0] gnt_lo,
  output logic             busy
);
  localparam int unsigned LVL_W = NUM_LVL;

  // reset: asserted at once, removed on a clock edge
  logic [SYNC_STG-1:0] rst_sync_q;
  logic                rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_STG-2:0], 1'b1};
    end
  end
  assign rst_n_s = rst_sync_q[SYNC_STG-1];

  logic [N_DEV-1:0] req_lvl  [LVL_W];
  logic [N_DEV-1:0] take_lvl [LVL_W];
  logic [LVL_W-1:0] lvl_line_req;
  logic [LVL_W-1:0] lvl_line_gnt;
  logic [LVL_W-1:0] lvl_pass;
  logic             idle;

  assign req_lvl[LVL_LO] = req_lo;
  assign req_lvl[LVL_HI] = req_hi;

  for (genvar l = 0; l < LVL_W; l++) begin : g_lvl
    assign lvl_line_req[l] = |req_lvl[l];

    arb2_grant_chain #(.N_DEV(N_DEV)) u_chain (
      .clk        (clk),
      .rst_n      (rst_n_s),
      .grant_line (lvl_line_gnt[l]),
      .req        (req_lvl[l]),
      .take       (take_lvl[l]),
      .pass_out   (lvl_pass[l])
    );

    // a driven grant line always finds a taker because the line only rises on a request
    a_r2_line_absorbed: assert property (@(posedge clk) disable iff (!rst_n_s)
      lvl_line_gnt[l] |-> !lvl_pass[l]);
  end

  arb2_level_select u_sel (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .idle       (idle),
    .lvl_req_hi (lvl_line_req[LVL_HI]),
    .lvl_req_lo (lvl_line_req[LVL_LO]),
    .gl_hi      (lvl_line_gnt[LVL_HI]),
    .gl_lo      (lvl_line_gnt[LVL_LO])
  );

  arb2_tenure #(.N_DEV(N_DEV)) u_ten (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .take_hi (take_lvl[LVL_HI]),
    .take_lo (take_lvl[LVL_LO]),
    .rel     (rel),
    .idle    (idle),
    .gnt_hi  (gnt_hi),
    .gnt_lo  (gnt_lo),
    .busy    (busy)
  );

  a_r3_low_blocked: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!busy && (req_hi != '0)) |=> (gnt_lo == '0));
endmodule

// File: tb/arb2_bus_arbiter_tb.sv
`timescale 1ns/1ps
module arb2_bus_arbiter_tb;
  localparam int N = 4;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] req_hi;
  logic [N-1:0] req_lo;
  logic         rel;
  logic [N-1:0] gnt_hi;
  logic [N-1:0] gnt_lo;
  logic         busy;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    logic [N-1:0] hi;
    logic [N-1:0] lo;
    string        tag;
  } exp_t;

  exp_t sb_q[$];

  // reference model state
  bit           m_busy = 0;
  bit           m_hi   = 0;
  logic [N-1:0] m_vec  = '0;

  arb2_bus_arbiter #(.N_DEV(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_hi(req_hi), .req_lo(req_lo),
    .rel(rel), .gnt_hi(gnt_hi), .gnt_lo(gnt_lo), .busy(busy)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [N-1:0] first_of(input logic [N-1:0] v);
    logic [N-1:0] r = '0;
    for (int i = N - 1; i >= 0; i--) if (v[i]) r = '0 | (1 << i);
    return r;
  endfunction

  task automatic check(input bit ok, input string what, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", what, act, exp);
    end
  endtask

  // apply one cycle of stimulus and queue the expected grant after the edge
  task automatic drive(input logic [N-1:0] hi, input logic [N-1:0] lo,
                       input logic r, input string tag);
    exp_t e;
    @(negedge clk);
    req_hi = hi;
    req_lo = lo;
    rel    = r;
    if (m_busy) begin
      if (r) begin
        m_busy = 0;
        m_vec  = '0;
      end
    end else if (hi != '0) begin
      m_busy = 1; m_hi = 1; m_vec = first_of(hi);
    end else if (lo != '0) begin
      m_busy = 1; m_hi = 0; m_vec = first_of(lo);
    end
    e.hi  = (m_busy && m_hi)  ? m_vec : '0;
    e.lo  = (m_busy && !m_hi) ? m_vec : '0;
    e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    exp_t e;
    #2;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      check(gnt_hi == e.hi && gnt_lo == e.lo, e.tag,
            $sformatf("hi=%b lo=%b", gnt_hi, gnt_lo),
            $sformatf("hi=%b lo=%b", e.hi, e.lo));
      check(busy == ((e.hi | e.lo) != '0) &&
            ($countones({gnt_hi, gnt_lo}) == (busy ? 1 : 0)),
            {e.tag, " R8 busy/one-grant"},
            $sformatf("busy=%0b n=%0d", busy, $countones({gnt_hi, gnt_lo})),
            $sformatf("busy=%0b", (e.hi | e.lo) != '0));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_hi = '0; req_lo = '0; rel = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    check(gnt_hi == '0 && gnt_lo == '0 && !busy, "R1 reset state",
          $sformatf("%b %b %0b", gnt_hi, gnt_lo, busy), "0000 0000 0");
    @(negedge clk);
    rst_n = 1'b1;
    req_hi = 4'b1111;   // requests must stay unserved until reset sync lets go
    @(posedge clk);
    #2;
    check(gnt_hi == '0 && !busy, "R1 sync release",
          $sformatf("%b %0b", gnt_hi, busy), "0000 0");
    req_hi = '0;
    repeat (3) @(posedge clk);

    drive('0, '0, 1'b1, "R7 release while idle");
    drive('0, '0, 1'b0, "R7 stays idle");
    drive(4'b0110, '0, 1'b0, "R2 R4 grant nearest high");
    drive('0, 4'b0001, 1'b0, "R10 owner dropped request");
    drive(4'b0001, 4'b0001, 1'b0, "R5 no preempt by nearer high");
    drive(4'b0001, 4'b1000, 1'b1, "R6 release clears");
    drive(4'b0001, 4'b1000, 1'b0, "R6 R3 regrant after idle");
    drive(4'b0001, 4'b1000, 1'b1, "R6 release again");
    drive('0, 4'b1100, 1'b1, "R7 R4 release idle with low req");
    drive(4'b0010, 4'b1100, 1'b0, "R5 low owner keeps bus");
    drive(4'b1111, 4'b0000, 1'b0, "R5 hold against high level");
    drive(4'b1000, 4'b0000, 1'b1, "R6 low releases");
    drive(4'b1000, 4'b0001, 1'b0, "R3 both levels high wins");
    drive('0, '0, 1'b1, "R6 release to idle");
    for (int r = 0; r < 5; r++) begin
      drive(4'b0100, 4'b0011, 1'b0, "R9 high keeps winning");
      drive(4'b0100, 4'b0011, 1'b0, "R9 tenure held");
      drive(4'b0100, 4'b0011, 1'b1, "R9 release");
    end
    drive('0, 4'b0011, 1'b0, "R9 low served once high stops");
    drive('0, '0, 1'b1, "R6 final release");
    drive('0, '0, 1'b0, "R7 idle at end");
    repeat (2) @(posedge clk);
    #3;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule